// File: doc/BRIEF.md
# Set/Reset Coil Command Arbiter

This block sits behind the control register of a magnetoresistive sensor and turns the two coil-command bits into pulse requests for an external coil driver. A register write strobe delivers the written byte. Bit 1 asks for a SET pulse, which drives coil current in the forward direction. Bit 2 asks for a RESET pulse, which drives it in reverse. The block latches the accepted command and shows its bit for readback. It waits until the timing rules allow the pulse, then raises the matching pulse request and holds it until the driver reports completion. At that point it clears the bit, records which action ran, and returns to sleep.

A low-voltage mode input changes the rules. In that mode the actions must alternate, and a RESET cannot be the first action after power-up. The capacitor that feeds the coil also needs a settling interval after each pulse. In every mode, no pulse may start until a power-up interval has passed. Commands that break a rule are dropped at once and flagged for one cycle. Commands that arrive early but are legal are held until their interval has run out. All intervals are counted in system clock cycles and set by parameters.

Top module: `coil_cmd_arbiter`

## Requirements
- R1: After reset both command bits read 0, both pulse requests are low, the reject flag is low and the sleep output is high.
- R2: When the block is asleep, a write whose bit 1 is 1 latches the SET bit, and a write whose bit 2 is 1 and bit 1 is 0 latches the RESET bit; either bit reads back as 1 from the cycle after the write. A write with bits 1 and 2 both 0 changes nothing and raises no reject.
- R3: A write with bits 1 and 2 both set runs only the SET action; the RESET bit stays 0.
- R4: A pulse request is high only while its bit is 1, and it stays high until the done input is sampled. On that edge the bit clears, the request drops and the sleep output returns to 1. The sleep output is 0 from the write that latched the command until that edge.
- R5: No pulse request rises before PWRUP_CYC+1 clock edges after reset is released. A command latched earlier starts its pulse exactly on that edge.
- R6: In low-voltage mode (sampled with the write), a command of the same kind as the last completed action is rejected.
- R7: In low-voltage mode, a RESET command is rejected while no action has completed since reset.
- R8: For a command accepted in low-voltage mode, the pulse starts no earlier than SETTLE_CYC+1 edges after the done input ended the previous pulse.
- R9: Outside low-voltage mode, repeated commands of one kind and a first RESET are accepted, and no settling interval applies. If the power-up interval is over, the pulse starts on the edge after the write.
- R10: A rejected command leaves both bits unchanged and raises the reject flag for exactly the cycle after the write. Commands written while a command is pending or pulsing are rejected.
- R11: The done input has no effect unless a pulse request is high.
- R12: The two pulse requests are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release marks power-up |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | DATA_W | Byte written to the control register |
| low_volt_i | input | 1 | Low-voltage operating mode, sampled with the write |
| coil_done_i | input | 1 | Coil driver reports the pulse finished |
| set_pulse_o | output | 1 | Request a forward-current coil pulse |
| rst_pulse_o | output | 1 | Request a reverse-current coil pulse |
| set_bit_o | output | 1 | Live SET bit for readback |
| rst_bit_o | output | 1 | Live RESET bit for readback |
| reject_o | output | 1 | One-cycle flag for a dropped command |
| sleep_o | output | 1 | No command pending or pulsing |

## Verification
The bench writes early commands during the power-up window. A design that counted the interval from the wrong edge, or that dropped instead of holding the command, would start the pulse a cycle off or never start it. It repeats commands in low-voltage mode and issues a first RESET, so a design that ignored the history register would pulse where it must reject. After each completion it immediately requests the opposite action, so a settle counter that is loaded late or tested off by one would show up as a shifted rising edge. It also writes both bits together, writes while the block is busy, and pulses done while idle. A wrong SET priority, a missing busy guard, or done logic that is not gated would then show as a wrong bit, a missing reject, or a spurious wake.

// File: rtl/coil_pkg.sv
package coil_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_RST  = 2'd2
  } coil_act_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_PULSE = 2'd2
  } coil_st_e;
endpackage

// File: rtl/coil_gap_timer.sv
// Down-counter: ready when zero. Reloads on load_i; START_FULL loads at reset.
module coil_gap_timer #(
  parameter int unsigned CYCLES     = 16,
  parameter bit          START_FULL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic ready_o
);
  localparam int unsigned W = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);
  localparam logic [W-1:0] LOAD_VAL = W'(CYCLES);
  localparam logic [W-1:0] RST_VAL  = START_FULL ? LOAD_VAL : '0;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RST_VAL;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/coil_cmd_filter.sv
// Decodes a write into an action and applies the ordering rules.
module coil_cmd_filter
  import coil_pkg::*;
(
  input  logic      set_req_i,
  input  logic      rst_req_i,
  input  logic      lv_i,
  input  logic      idle_i,
  input  coil_act_e last_i,
  output logic      cmd_o,
  output logic      accept_o,
  output coil_act_e act_o
);
  coil_act_e act;
  logic      blocked;

  always_comb begin
    if (set_req_i)      act = ACT_SET;   // SET wins over RESET
    else if (rst_req_i) act = ACT_RST;
    else                act = ACT_NONE;

    blocked = 1'b0;
    if (lv_i) begin
      if (act == ACT_SET && last_i == ACT_SET) blocked = 1'b1;
      if (act == ACT_RST && last_i != ACT_SET) blocked = 1'b1;
    end

    cmd_o    = set_req_i | rst_req_i;
    accept_o = cmd_o & idle_i & ~blocked;
    act_o    = act;
  end
endmodule

// File: rtl/coil_cmd_arbiter.sv
module coil_cmd_arbiter
  import coil_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SET_POS    = 1,
  parameter int unsigned RST_POS    = 2,
  parameter int unsigned SETTLE_CYC = 1_250_000,
  parameter int unsigned PWRUP_CYC  = 2_500_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              low_volt_i,
  input  logic              coil_done_i,
  output logic              set_pulse_o,
  output logic              rst_pulse_o,
  output logic              set_bit_o,
  output logic              rst_bit_o,
  output logic              reject_o,
  output logic              sleep_o
);
  localparam logic [DATA_W-1:0] CMD_MASK =
    DATA_W'((1 << SET_POS) | (1 << RST_POS));

  coil_st_e  state_q;
  coil_act_e act_q, last_q, dec_act;
  logic      lv_q, set_bit_q, rst_bit_q, reject_q;
  logic      dec_cmd, dec_ok, idle, done_hit;
  logic      pwr_ready, settle_ready, go;
  logic      unused_bits;

  assign unused_bits = ^(wr_data_i & ~CMD_MASK);

  assign idle     = (state_q == ST_IDLE);
  assign done_hit = (state_q == ST_PULSE) & coil_done_i;

  coil_cmd_filter u_filter (
    .set_req_i (wr_data_i[SET_POS]),
    .rst_req_i (wr_data_i[RST_POS]),
    .lv_i      (low_volt_i),
    .idle_i    (idle),
    .last_i    (last_q),
    .cmd_o     (dec_cmd),
    .accept_o  (dec_ok),
    .act_o     (dec_act)
  );

  coil_gap_timer #(.CYCLES(PWRUP_CYC), .START_FULL(1'b1)) u_pwrup (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (1'b0),
    .ready_o (pwr_ready)
  );

  coil_gap_timer #(.CYCLES(SETTLE_CYC), .START_FULL(1'b0)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (done_hit),
    .ready_o (settle_ready)
  );

  // settle gap only binds commands accepted in low-voltage mode
  assign go = pwr_ready & (~lv_q | settle_ready);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      act_q     <= ACT_NONE;
      last_q    <= ACT_NONE;
      lv_q      <= 1'b0;
      set_bit_q <= 1'b0;
      rst_bit_q <= 1'b0;
      reject_q  <= 1'b0;
    end else begin
      reject_q <= wr_en_i & dec_cmd & ~dec_ok;
      unique case (state_q)
        ST_IDLE: begin
          if (wr_en_i && dec_ok) begin
            state_q   <= ST_ARM;
            act_q     <= dec_act;
            lv_q      <= low_volt_i;
            set_bit_q <= (dec_act == ACT_SET);
            rst_bit_q <= (dec_act == ACT_RST);
          end
        end
        ST_ARM: begin
          if (go) state_q <= ST_PULSE;
        end
        ST_PULSE: begin
          if (coil_done_i) begin
            state_q   <= ST_IDLE;
            last_q    <= act_q;
            set_bit_q <= 1'b0;
            rst_bit_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign set_pulse_o = (state_q == ST_PULSE) & (act_q == ACT_SET);
  assign rst_pulse_o = (state_q == ST_PULSE) & (act_q == ACT_RST);
  assign set_bit_o   = set_bit_q;
  assign rst_bit_o   = rst_bit_q;
  assign reject_o    = reject_q;
  assign sleep_o     = idle;
endmodule

// File: rtl/coil_cmd_arbiter_chk.sv
module coil_cmd_arbiter_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SET_POS   = 1,
  parameter int unsigned RST_POS   = 2,
  parameter int unsigned PWRUP_CYC = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              coil_done_i,
  input logic              set_pulse_o,
  input logic              rst_pulse_o,
  input logic              set_bit_o,
  input logic              rst_bit_o,
  input logic              sleep_o
);
  logic [31:0] up_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 up_cnt <= '0;
    else if (up_cnt <= PWRUP_CYC) up_cnt <= up_cnt + 1'b1;
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_pulse_o && rst_pulse_o)); // R12

  AST_SET_PULSE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_pulse_o |-> set_bit_o); // R4

  AST_RST_PULSE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |-> rst_bit_o); // R4

  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_pulse_o || rst_pulse_o) && coil_done_i |=> !set_bit_o && !rst_bit_o && sleep_o); // R4

  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> !set_pulse_o && !rst_pulse_o); // R4

  AST_SET_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[SET_POS] && wr_data_i[RST_POS] && sleep_o |=> !rst_bit_o); // R3

  AST_PWRUP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_pulse_o || rst_pulse_o) |-> (up_cnt > PWRUP_CYC)); // R5

  AST_IDLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o && coil_done_i && !wr_en_i |=> sleep_o && !set_bit_o && !rst_bit_o); // R11
endmodule

bind coil_cmd_arbiter coil_cmd_arbiter_chk #(
  .DATA_W   (DATA_W),
  .SET_POS  (SET_POS),
  .RST_POS  (RST_POS),
  .PWRUP_CYC(PWRUP_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .coil_done_i (coil_done_i),
  .set_pulse_o (set_pulse_o),
  .rst_pulse_o (rst_pulse_o),
  .set_bit_o   (set_bit_o),
  .rst_bit_o   (rst_bit_o),
  .sleep_o     (sleep_o)
);

// File: tb/coil_cmd_arbiter_tb_top.sv
`timescale 1ns/100ps
module coil_cmd_arbiter_tb_top;
  localparam int PWR = 100;
  localparam int STL = 40;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, lv = 1'b0, coil_done = 1'b0;
  logic [7:0] wd = 8'h00;
  logic       set_pulse, rst_pulse, set_bit, rst_bit, reject, sleep;

  always #2 clk = ~clk;

  coil_cmd_arbiter #(.SETTLE_CYC(STL), .PWRUP_CYC(PWR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wd),
    .low_volt_i(lv), .coil_done_i(coil_done),
    .set_pulse_o(set_pulse), .rst_pulse_o(rst_pulse),
    .set_bit_o(set_bit), .rst_bit_o(rst_bit),
    .reject_o(reject), .sleep_o(sleep)
  );

  int checks = 0, errors = 0, cyc = 0;
  int dly = 3, pcnt = 0, done_cyc = 0;
  bit force_done = 1'b0, finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  // reference model: state 0 sleep, 1 armed, 2 pulsing; kind 0 none, 1 set, 2 reset
  int m_state, m_kind, m_last, m_pw, m_st;
  bit m_lv, m_setb, m_rstb, m_rej;

  always @(posedge clk or negedge rst_n) begin : mdl
    int ns, nk, nl, npw, nst;
    bit nlv, nsb, nrb, nrej, s, r, go;
    if (!rst_n) begin
      m_state = 0; m_kind = 0; m_last = 0; m_pw = PWR; m_st = 0;
      m_lv = 0; m_setb = 0; m_rstb = 0; m_rej = 0;
    end else begin
      ns = m_state; nk = m_kind; nl = m_last; npw = m_pw; nst = m_st;
      nlv = m_lv; nsb = m_setb; nrb = m_rstb; nrej = 0;
      go = (m_pw == 0) && (!m_lv || m_st == 0);
      if (m_pw > 0) npw = m_pw - 1;
      if (m_state == 2 && coil_done) nst = STL;
      else if (m_st > 0) nst = m_st - 1;
      if (m_state == 1 && go) ns = 2;
      if (m_state == 2 && coil_done) begin
        ns = 0; nl = m_kind; nsb = 0; nrb = 0;
      end
      if (wr_en) begin
        s = wd[1];
        r = wd[2] && !wd[1];
        if (s || r) begin
          if (m_state != 0) nrej = 1;
          else if (lv && ((s && m_last == 1) || (r && m_last != 1))) nrej = 1;
          else begin
            ns = 1; nk = s ? 1 : 2; nlv = lv; nsb = s; nrb = r;
          end
        end
      end
      m_state = ns; m_kind = nk; m_last = nl; m_pw = npw; m_st = nst;
      m_lv = nlv; m_setb = nsb; m_rstb = nrb; m_rej = nrej;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !finished) begin
    #1;
    chk(set_pulse == (m_state == 2 && m_kind == 1), "R4 set_pulse", set_pulse, m_state == 2 && m_kind == 1);
    chk(rst_pulse == (m_state == 2 && m_kind == 2), "R4 rst_pulse", rst_pulse, m_state == 2 && m_kind == 2);
    chk(set_bit == m_setb, "R2 set_bit", set_bit, m_setb);
    chk(rst_bit == m_rstb, "R2 rst_bit", rst_bit, m_rstb);
    chk(reject == m_rej, "R10 reject", reject, m_rej);
    chk(sleep == (m_state == 0), "R4 sleep", sleep, m_state == 0);
    chk(!(set_pulse && rst_pulse), "R12 both pulses", set_pulse && rst_pulse, 0);
  end

  // coil driver stand-in
  always @(negedge clk) begin
    #0.5;
    if (set_pulse || rst_pulse) begin
      pcnt++;
      coil_done = (pcnt == dly) || force_done;
      if (pcnt == dly) begin
        pcnt = 0;
        done_cyc = cyc + 1;
      end
    end else begin
      pcnt = 0;
      coil_done = force_done;
    end
  end

  task automatic wr(input logic [7:0] d, input bit v);
    @(negedge clk);
    wd = d; lv = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wd = 8'h00;
    #1;
  endtask

  task automatic wait_rise(output int at);
    while (!(set_pulse || rst_pulse)) begin
      @(negedge clk); #1;
    end
    at = cyc;
  endtask

  task automatic wait_sleep();
    while (!sleep) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic report();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R4 watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    int rise, wcyc, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!set_bit && !rst_bit, "R1 bits", {set_bit, rst_bit}, 0);
    chk(!set_pulse && !rst_pulse && !reject, "R1 outputs", {set_pulse, rst_pulse, reject}, 0);
    chk(sleep == 1'b1, "R1 sleep", sleep, 1);

    // R11 done while idle
    @(negedge clk); force_done = 1'b1;
    repeat (2) @(negedge clk); force_done = 1'b0;
    @(negedge clk); #1;
    chk(sleep && !set_bit && !rst_bit, "R11 idle done", sleep, 1);

    // R2 write with both command bits clear
    wr(8'hF9, 1'b0);
    chk(!set_bit && !rst_bit && !reject && sleep, "R2 no command", {set_bit, rst_bit, reject}, 0);

    // R5 early SET held until the power-up interval ends
    wr(8'h02, 1'b0);
    chk(set_bit == 1'b1, "R2 set latched", set_bit, 1);
    wr(8'h04, 1'b0);
    chk(reject == 1'b1, "R10 busy reject", reject, 1);
    chk(rst_bit == 1'b0, "R10 busy bit", rst_bit, 0);
    wait_rise(rise);
    chk(rise == PWR + 1, "R5 power-up hold", rise, PWR + 1);
    wait_sleep();

    // R9 repeat SET in normal mode starts at once
    wr(8'h02, 1'b0);
    wcyc = cyc;
    wait_rise(rise);
    chk(rise == wcyc + 1, "R9 immediate repeat", rise, wcyc + 1);
    wait_sleep();

    // R6 repeated SET in low-voltage mode
    wr(8'h02, 1'b1);
    chk(reject == 1'b1 && !set_bit, "R6 repeat set", reject, 1);

    // R3 both bits: only SET
    wr(8'h06, 1'b0);
    chk(set_bit && !rst_bit, "R3 set priority", {set_bit, rst_bit}, 2);
    wait_sleep();

    // R8 low-voltage RESET waits for the settle interval
    wr(8'h04, 1'b1);
    chk(rst_bit == 1'b1, "R2 reset latched", rst_bit, 1);
    wait_rise(rise);
    chk(rise == done_cyc + STL + 1, "R8 settle hold", rise, done_cyc + STL + 1);
    chk(rst_pulse == 1'b1, "R8 reset pulse", rst_pulse, 1);
    wait_sleep();

    // R6 repeated RESET in low-voltage mode
    wr(8'h04, 1'b1);
    chk(reject == 1'b1 && !rst_bit, "R6 repeat reset", reject, 1);
    wr(8'h02, 1'b1);
    chk(set_bit == 1'b1 && !reject, "R6 alternate set", set_bit, 1);
    wait_sleep();

    // R7 first RESET after power-up in low-voltage mode
    do_reset();
    wr(8'h04, 1'b1);
    chk(reject == 1'b1 && !rst_bit, "R7 first reset", reject, 1);
    wr(8'h04, 1'b0);
    chk(rst_bit == 1'b1 && !reject, "R9 first reset normal", rst_bit, 1);
    wait_sleep();

    // R4 pulse held until done
    dly = 10;
    wr(8'h02, 1'b0);
    wait_rise(rise);
    hi = 0;
    while (set_pulse) begin
      hi++;
      @(negedge clk); #1;
    end
    chk(hi == 10, "R4 pulse length", hi, 10);
    chk(!set_bit && sleep, "R4 clear on done", set_bit, 0);

    repeat (3) @(negedge clk);
    report();
  end
endmodule